// File: doc/BRIEF.md
# Byte-Serial Register Request Executor

This block sits at the far end of a byte link and turns a stream of request bytes into accesses on a simple register bus. The bytes arrive already deframed, each with a valid strobe and a flag that marks the final byte of a request. The block gathers a fixed eight-byte header that carries an opcode, a byte count and a start address. It then performs the word reads or writes the request asks for and sends its answer back as a byte stream with its own valid and final-byte flags.

Write payload is collected in an internal word buffer first, so the bus is driven only once a request is known to be complete. Reads go straight to the bus one word at a time, and each word is serialized onto the response stream before the next read is issued. While a request is executing or being answered, the block ignores input bytes. The input has no back-pressure.

Top module: `txn_exec`

## Requirements
- R1: A request starts with 8 bytes in this order: opcode, one reserved byte (ignored), a 16-bit count most significant byte first, and a 32-bit byte address most significant byte first. The first bus access of a request uses that address.
- R2: Opcode 0x00 writes every payload word to the same address. Opcode 0x04 adds 4 to the address after each word. The number of bus writes is ceil(count/4).
- R3: Opcode 0x10 reads every word from one address and 0x14 adds 4 after each word. The response carries exactly count bytes, each word sent least significant byte first. The final-byte flag is set on the last byte only.
- R4: Write payload follows the header and is packed into 32-bit words with the first received byte in bits 7:0. A partial final word has its unused upper bytes set to zero.
- R5: When all of a write's bus accesses are done, the block answers with 4 bytes: opcode OR 0x80, 0x00, count[15:8], count[7:0]. The final-byte flag is set on the fourth byte.
- R6: An unknown opcode, or a write whose count exceeds MAX_BYTES, causes no bus access. It is answered after the request's final byte with the 4 bytes 0xFF, 0x00, 0x00, 0x00, with the final-byte flag on the fourth.
- R7: If the final-byte flag arrives before the header or the write payload is complete, the request is discarded with no bus access and no response, and the next byte is taken as a new header.
- R8: A bus request holds its address, write enable and write data steady until ready is seen. It is removed in the cycle after the request-and-ready cycle, so each word is transferred exactly once.
- R9: Input bytes that arrive after a write's payload is complete and before its response has been sent are ignored.
- R10: A write with count 0 makes no bus access and is answered with the acknowledge of R5 showing count 0. A read with count 0 makes no access and produces no response bytes.
- R11: After reset, no bus request and no response byte is presented, and the block waits for a header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_valid | input | 1 | Request byte strobe |
| rq_data | input | 8 | Request byte |
| rq_last | input | 1 | Marks the final byte of a request |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address of the access |
| bus_wdata | output | 32 | Write data word |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access accepted and completed |
| rs_valid | output | 1 | Response byte strobe |
| rs_data | output | 8 | Response byte |
| rs_last | output | 1 | Marks the final response byte |

## Verification
The bench builds the block with MAX_BYTES set to 32, an eight-word write buffer. This keeps the buffer small enough that an oversize write of 40 bytes, which must be refused, is cheap to send. The bus model answers with latencies from zero to two cycles. This exercises both back-to-back accept cycles and requests that must be held. Partial final words, repeated fixed-address accesses and truncated requests all fit inside the small address window the model decodes.

// File: rtl/txn_pkg.sv
package txn_pkg;

  localparam logic [7:0] OP_WR_FIX = 8'h00;
  localparam logic [7:0] OP_WR_INC = 8'h04;
  localparam logic [7:0] OP_RD_FIX = 8'h10;
  localparam logic [7:0] OP_RD_INC = 8'h14;

  // header fields that matter; reserved byte is skipped on capture
  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] cnt;
    logic [31:0] addr;
  } hdr_t;

  typedef enum logic [3:0] {
    ST_HDR,
    ST_DRAIN,
    ST_PAY,
    ST_WRD,
    ST_WLD,
    ST_WR,
    ST_RD,
    ST_RSEND,
    ST_ERR,
    ST_ACK,
    ST_WAIT
  } state_t;

endpackage

// File: rtl/txn_hdr_capture.sv
module txn_hdr_capture
  import txn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       hdr_done,
  output hdr_t       hdr
);

  logic [2:0]  idx;
  logic [47:0] sr;
  logic        take;

  assign take     = en && in_valid;
  assign hdr_done = take && (idx == 3'd7);
  assign hdr      = {sr, in_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= 3'd0;
      sr  <= '0;
    end else if (take) begin
      if (hdr_done || in_last) begin
        idx <= 3'd0;
      end else begin
        idx <= idx + 3'd1;
      end
      if (idx != 3'd1) begin
        sr <= {sr[39:0], in_data};
      end
    end
  end

  // R1
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !in_last && (idx != 3'd7)) |=> (idx == $past(idx) + 3'd1));

endmodule

// File: rtl/txn_wbuf.sv
module txn_wbuf #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW+1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic          wr_final,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);

  logic [31:0]   mem [DEPTH];
  logic [31:0]   pk;
  logic [31:0]   merged;
  logic [1:0]    lane;
  logic [AW-1:0] widx;

  assign lane = wr_idx[1:0];
  assign widx = wr_idx[AW+1:2];

  always_comb begin
    merged = (lane == 2'd0) ? 32'h0 : pk;
    merged[8*lane +: 8] = wr_byte;
  end

  always_ff @(posedge clk) begin
    if (wr_valid) begin
      pk <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid && ((lane == 2'd3) || wr_final)) begin
      mem[widx] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  // R4
  idx_order_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_final) |=> (!wr_valid || (wr_idx == $past(wr_idx) + 1'b1)));

endmodule

// File: rtl/txn_resp_tx.sv
module txn_resp_tx (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] ld_bytes,
  input  logic [2:0]  ld_n,
  input  logic        ld_last,
  output logic        busy,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last
);

  logic [23:0] sh;
  logic [2:0]  rem;
  logic        lastf;

  assign busy = (rem != 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      rem       <= 3'd0;
      lastf     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_bytes[7:0];
      sh        <= ld_bytes[31:8];
      rem       <= ld_n - 3'd1;
      lastf     <= ld_last;
      out_last  <= ld_last && (ld_n == 3'd1);
    end else if (rem != 3'd0) begin
      out_valid <= 1'b1;
      out_data  <= sh[7:0];
      sh        <= {8'h00, sh[23:8]};
      rem       <= rem - 3'd1;
      out_last  <= lastf && (rem == 3'd1);
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end

  // R3
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R9
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);

endmodule

// File: rtl/txn_exec.sv
module txn_exec
  import txn_pkg::*;
#(
  parameter int MAX_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rq_valid,
  input  logic [7:0]  rq_data,
  input  logic        rq_last,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ready,
  output logic        rs_valid,
  output logic [7:0]  rs_data,
  output logic        rs_last
);

  localparam int DEPTH = MAX_BYTES / 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int IW    = AW + 2;

  state_t        state;
  hdr_t          hdr;
  logic          hdr_done;
  logic [7:0]    op_q;
  logic [15:0]   cnt_q;
  logic [15:0]   cm1_q;
  logic [15:0]   rem_q;
  logic [IW-1:0] bidx;
  logic [AW-1:0] wcnt;
  logic [31:0]   wb_rdata;
  logic          wb_we;
  logic          pay_final;
  logic          known, is_wr, too_big;
  logic          tx_load, tx_last, tx_busy;
  logic [31:0]   tx_bytes;
  logic [2:0]    tx_n, rd_n;

  txn_hdr_capture u_hdr (
    .clk      (clk),
    .rst      (rst),
    .en       (state == ST_HDR),
    .in_valid (rq_valid),
    .in_data  (rq_data),
    .in_last  (rq_last),
    .hdr_done (hdr_done),
    .hdr      (hdr)
  );

  assign wb_we     = (state == ST_PAY) && rq_valid;
  assign pay_final = (16'(bidx) == cm1_q);

  txn_wbuf #(.DEPTH(DEPTH), .AW(AW)) u_wbuf (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wb_we),
    .wr_idx   (bidx),
    .wr_byte  (rq_data),
    .wr_final (pay_final),
    .rd_addr  (wcnt),
    .rd_data  (wb_rdata)
  );

  assign is_wr   = (hdr.op == OP_WR_FIX) || (hdr.op == OP_WR_INC);
  assign known   = is_wr || (hdr.op == OP_RD_FIX) || (hdr.op == OP_RD_INC);
  assign too_big = is_wr && ({1'b0, hdr.cnt} > 17'(MAX_BYTES));
  assign rd_n    = (rem_q >= 16'd4) ? 3'd4 : rem_q[2:0];

  always_comb begin
    tx_load  = 1'b0;
    tx_bytes = 32'h0;
    tx_n     = 3'd4;
    tx_last  = 1'b1;
    case (state)
      ST_ERR: begin
        tx_load  = 1'b1;
        tx_bytes = 32'h0000_00FF;
      end
      ST_ACK: begin
        tx_load  = 1'b1;
        tx_bytes = {cnt_q[7:0], cnt_q[15:8], 8'h00, op_q | 8'h80};
      end
      ST_RD: begin
        if (bus_req && bus_ready) begin
          tx_load  = 1'b1;
          tx_bytes = bus_rdata;
          tx_n     = rd_n;
          tx_last  = (rem_q <= 16'd4);
        end
      end
      default: ;
    endcase
  end

  txn_resp_tx u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (tx_load),
    .ld_bytes  (tx_bytes),
    .ld_n      (tx_n),
    .ld_last   (tx_last),
    .busy      (tx_busy),
    .out_valid (rs_valid),
    .out_data  (rs_data),
    .out_last  (rs_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HDR;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      op_q      <= '0;
      cnt_q     <= '0;
      cm1_q     <= '0;
      rem_q     <= '0;
      bidx      <= '0;
      wcnt      <= '0;
    end else begin
      case (state)
        ST_HDR: begin
          if (hdr_done) begin
            op_q     <= hdr.op;
            cnt_q    <= hdr.cnt;
            cm1_q    <= hdr.cnt - 16'd1;
            rem_q    <= hdr.cnt;
            bus_addr <= hdr.addr;
            bidx     <= '0;
            wcnt     <= '0;
            if (!known || too_big) begin
              state <= rq_last ? ST_ERR : ST_DRAIN;
            end else if (is_wr) begin
              if (hdr.cnt == 16'd0)  state <= ST_ACK;
              else if (rq_last)      state <= ST_HDR;
              else                   state <= ST_PAY;
            end else if (hdr.cnt == 16'd0) begin
              state <= ST_HDR;
            end else begin
              bus_req <= 1'b1;
              bus_we  <= 1'b0;
              state   <= ST_RD;
            end
          end
        end
        ST_DRAIN: begin
          if (rq_valid && rq_last) state <= ST_ERR;
        end
        ST_PAY: begin
          if (rq_valid) begin
            bidx <= bidx + 1'b1;
            if (pay_final)    state <= ST_WRD;
            else if (rq_last) state <= ST_HDR;
          end
        end
        ST_WRD: state <= ST_WLD;
        ST_WLD: begin
          bus_wdata <= wb_rdata;
          bus_req   <= 1'b1;
          bus_we    <= 1'b1;
          state     <= ST_WR;
        end
        ST_WR: begin
          if (bus_ready) begin
            bus_req <= 1'b0;
            bus_we  <= 1'b0;
            if (op_q[2]) bus_addr <= bus_addr + 32'd4;
            if (wcnt == cm1_q[AW+1:2]) begin
              state <= ST_ACK;
            end else begin
              wcnt  <= wcnt + 1'b1;
              state <= ST_WRD;
            end
          end
        end
        ST_RD: begin
          if (bus_ready) begin
            bus_req <= 1'b0;
            rem_q   <= rem_q - {13'b0, rd_n};
            if (op_q[2]) bus_addr <= bus_addr + 32'd4;
            state   <= ST_RSEND;
          end
        end
        ST_RSEND: begin
          if (!tx_busy) begin
            if (rem_q == 16'd0) begin
              state <= ST_HDR;
            end else begin
              bus_req <= 1'b1;
              state   <= ST_RD;
            end
          end
        end
        ST_ERR, ST_ACK: state <= ST_WAIT;
        ST_WAIT: begin
          if (!tx_busy) state <= ST_HDR;
        end
        default: state <= ST_HDR;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ready) |=> !bus_req);

  // R7
  parse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_HDR) || (state == ST_PAY) || (state == ST_DRAIN) || (state == ST_ERR)) |-> !bus_req);

  // R5
  ack_first_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK) |=> (rs_valid && (rs_data == (op_q | 8'h80))));

  // R2
  fixed_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ready && !op_q[2]) |=> $stable(bus_addr));

  // R2
  inc_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ready && op_q[2]) |=> (bus_addr == $past(bus_addr) + 32'd4));

endmodule

// File: tb/txn_exec_bench.sv
`timescale 1ns/1ps
module txn_exec_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rq_valid = 1'b0;
  logic [7:0]  rq_data = 8'h00;
  logic        rq_last = 1'b0;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = 32'h0;
  logic        bus_ready = 1'b0;
  logic        rs_valid, rs_last;
  logic [7:0]  rs_data;

  always #2 clk = ~clk;

  txn_exec #(.MAX_BYTES(32)) u_txn_exec (
    .clk(clk), .rst(rst), .rq_valid(rq_valid), .rq_data(rq_data), .rq_last(rq_last),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .rs_valid(rs_valid), .rs_data(rs_data), .rs_last(rs_last)
  );

  // bus model
  bit [31:0]   smem [64];
  bit [31:0]   exp_mem [64];
  int          lat = 0;
  int          lat_cnt = 0;
  logic [31:0] acc_a [256];
  logic        acc_w [256];
  logic [31:0] acc_d [256];
  int          acc_n = 0;

  always @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      lat_cnt   <= 0;
    end else if (bus_req && bus_ready) begin
      bus_ready <= 1'b0;
      lat_cnt   <= 0;
      if (bus_we) smem[bus_addr[7:2]] <= bus_wdata;
      acc_a[acc_n] <= bus_addr;
      acc_w[acc_n] <= bus_we;
      acc_d[acc_n] <= bus_wdata;
      acc_n <= acc_n + 1;
    end else if (bus_req) begin
      if (lat_cnt >= lat) begin
        bus_ready <= 1'b1;
        bus_rdata <= smem[bus_addr[7:2]];
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // response monitor
  logic [7:0] rx_d [256];
  logic       rx_l [256];
  int         rx_n = 0;

  always @(negedge clk) begin
    if (!rst && rs_valid) begin
      rx_d[rx_n] <= rs_data;
      rx_l[rx_n] <= rs_last;
      rx_n <= rx_n + 1;
    end
  end

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [7:0] sb [80];
  int         sn = 0;

  task automatic push(input logic [7:0] b);
    sb[sn] = b;
    sn++;
  endtask

  task automatic push_hdr(input logic [7:0] op, input logic [15:0] cnt, input logic [31:0] addr);
    push(op); push(8'h00); push(cnt[15:8]); push(cnt[7:0]);
    push(addr[31:24]); push(addr[23:16]); push(addr[15:8]); push(addr[7:0]);
  endtask

  task automatic send_all(input bit with_last);
    for (int i = 0; i < sn; i++) begin
      rq_valid = 1'b1;
      rq_data  = sb[i];
      rq_last  = with_last && (i == sn - 1);
      @(posedge clk); #1;
    end
    rq_valid = 1'b0;
    rq_last  = 1'b0;
    sn = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_err_resp(input int base_a, input int base_r, input string tag);
    chk(acc_n == base_a, tag, acc_n - base_a, 0);
    chk(rx_n - base_r == 4, tag, rx_n - base_r, 4);
    chk(rx_d[base_r] == 8'hFF && rx_d[base_r+1] == 8'h00 && rx_d[base_r+2] == 8'h00 &&
        rx_d[base_r+3] == 8'h00, tag, {rx_d[base_r], rx_d[base_r+1], rx_d[base_r+2], rx_d[base_r+3]},
        32'hFF00_0000);
    chk(rx_l[base_r+3] && !rx_l[base_r], tag, {31'b0, rx_l[base_r+3]}, 1);
  endtask

  task automatic run_vec(input logic [7:0] op, input logic [15:0] cnt, input logic [31:0] addr,
                         input logic [7:0] seed);
    int base_a, base_r, nw;
    bit inc, wr;
    logic [31:0] ea, word;
    base_a = acc_n;
    base_r = rx_n;
    nw  = (int'(cnt) + 3) / 4;
    inc = op[2];
    wr  = (op == 8'h00) || (op == 8'h04);
    push_hdr(op, cnt, addr);
    if (wr) for (int i = 0; i < int'(cnt); i++) push(8'(int'(seed) + i));
    send_all(1'b1);
    wait_cyc(40 + int'(cnt) * 8);
    chk(acc_n - base_a == nw, "R8 access count", acc_n - base_a, nw);
    for (int k = 0; k < nw; k++) begin
      ea = inc ? addr + 32'(4 * k) : addr;
      chk(acc_a[base_a+k] == ea, (k == 0) ? "R1 first address" : (wr ? "R2 write address" : "R3 read address"),
          acc_a[base_a+k], ea);
      chk(acc_w[base_a+k] == wr, "R2 R3 access direction", {31'b0, acc_w[base_a+k]}, {31'b0, wr});
      if (wr) begin
        word = 32'h0;
        for (int j = 0; j < 4; j++)
          if (4 * k + j < int'(cnt)) word[8*j +: 8] = 8'(int'(seed) + 4 * k + j);
        chk(acc_d[base_a+k] == word, "R4 write word", acc_d[base_a+k], word);
        exp_mem[ea[7:2]] = word;
      end
    end
    if (wr) begin
      chk(rx_n - base_r == 4, "R5 ack length", rx_n - base_r, 4);
      chk({rx_d[base_r], rx_d[base_r+1], rx_d[base_r+2], rx_d[base_r+3]} == {op | 8'h80, 8'h00, cnt},
          "R5 ack bytes", {rx_d[base_r], rx_d[base_r+1], rx_d[base_r+2], rx_d[base_r+3]},
          {op | 8'h80, 8'h00, cnt});
      chk(rx_l[base_r+3] && !rx_l[base_r+2], "R5 ack last flag", {31'b0, rx_l[base_r+3]}, 1);
    end else begin
      chk(rx_n - base_r == int'(cnt), "R3 read length", rx_n - base_r, cnt);
      for (int i = 0; i < int'(cnt); i++) begin
        ea   = inc ? addr + 32'(4 * (i / 4)) : addr;
        word = exp_mem[ea[7:2]];
        chk(rx_d[base_r+i] == word[8*(i%4) +: 8], "R3 read byte", rx_d[base_r+i], word[8*(i%4) +: 8]);
        chk(rx_l[base_r+i] == (i == int'(cnt) - 1), "R3 read last flag", {31'b0, rx_l[base_r+i]},
            {31'b0, (i == int'(cnt) - 1)});
      end
    end
  endtask

  // {opcode, count, address, seed}
  localparam logic [63:0] VEC [7] = '{
    {8'h04, 16'd8, 32'h0000_0010, 8'h11},
    {8'h14, 16'd8, 32'h0000_0010, 8'h00},
    {8'h00, 16'd3, 32'h0000_0040, 8'hA0},
    {8'h10, 16'd4, 32'h0000_0040, 8'h00},
    {8'h00, 16'd6, 32'h0000_0020, 8'h30},
    {8'h14, 16'd7, 32'h0000_0010, 8'h00},
    {8'h10, 16'd6, 32'h0000_0040, 8'h00}
  };

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int ba, br;
    wait_cyc(5);
    // R11 reset state
    chk(!bus_req && !rs_valid, "R11 reset outputs", {30'b0, bus_req, rs_valid}, 0);
    rst = 1'b0;
    wait_cyc(3);
    chk(!bus_req && !rs_valid && acc_n == 0, "R11 idle after reset", {30'b0, bus_req, rs_valid}, 0);

    for (int v = 0; v < 7; v++) begin
      lat = v % 3;
      run_vec(VEC[v][63:56], VEC[v][55:40], VEC[v][39:8], VEC[v][7:0]);
    end

    // R6 unknown opcode, last on header end
    ba = acc_n; br = rx_n;
    push_hdr(8'h22, 16'd4, 32'h0);
    send_all(1'b1);
    wait_cyc(20);
    chk_err_resp(ba, br, "R6 unknown opcode");

    // R6 unknown opcode with trailing bytes; answer only after last
    ba = acc_n; br = rx_n;
    push_hdr(8'h08, 16'd4, 32'h0);
    push(8'h01); push(8'h02); push(8'h03);
    send_all(1'b1);
    wait_cyc(20);
    chk_err_resp(ba, br, "R6 unknown opcode drained");

    // R6 oversize write
    ba = acc_n; br = rx_n;
    push_hdr(8'h04, 16'd40, 32'h0);
    for (int i = 0; i < 40; i++) push(8'(i));
    send_all(1'b1);
    wait_cyc(20);
    chk_err_resp(ba, br, "R6 oversize write");

    // R7 header cut short
    ba = acc_n; br = rx_n;
    push(8'h14); push(8'h00); push(8'h00); push(8'h08); push(8'h00);
    send_all(1'b1);
    wait_cyc(20);
    chk(acc_n == ba && rx_n == br, "R7 short header dropped", rx_n - br, 0);

    // R7 payload cut short, memory must be untouched
    ba = acc_n; br = rx_n;
    push_hdr(8'h04, 16'd8, 32'h10);
    for (int i = 0; i < 5; i++) push(8'hE0 + 8'(i));
    send_all(1'b1);
    wait_cyc(20);
    chk(acc_n == ba && rx_n == br, "R7 short payload dropped", acc_n - ba, 0);
    run_vec(8'h14, 16'd8, 32'h10, 8'h00);

    // R10 zero-count write and read
    ba = acc_n; br = rx_n;
    push_hdr(8'h04, 16'd0, 32'h0);
    send_all(1'b1);
    wait_cyc(20);
    chk(acc_n == ba, "R10 zero write no access", acc_n - ba, 0);
    chk(rx_n - br == 4 && rx_d[br] == 8'h84 && rx_d[br+2] == 8'h00 && rx_d[br+3] == 8'h00 && rx_l[br+3],
        "R10 zero write ack", {rx_d[br], rx_d[br+1], rx_d[br+2], rx_d[br+3]}, 32'h8400_0000);
    ba = acc_n; br = rx_n;
    push_hdr(8'h10, 16'd0, 32'h0);
    send_all(1'b1);
    wait_cyc(20);
    chk(acc_n == ba && rx_n == br, "R10 zero read silent", rx_n - br, 0);

    // R9 bytes during execution ignored
    lat = 2;
    ba = acc_n; br = rx_n;
    push_hdr(8'h00, 16'd4, 32'h80);
    push(8'h50); push(8'h51); push(8'h52); push(8'h53);
    push(8'h10); push(8'h00); push(8'h00);
    send_all(1'b0);
    wait_cyc(30);
    chk(acc_n - ba == 1 && acc_d[ba] == 32'h5352_5150, "R9 single write only", acc_n - ba, 1);
    chk(rx_n - br == 4 && rx_d[br] == 8'h80, "R9 only ack returned", rx_n - br, 4);
    exp_mem[32] = 32'h5352_5150;
    run_vec(8'h10, 16'd4, 32'h80, 8'h00);

    summary();
  end

endmodule